// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable logic device. It takes the single sum term produced by an AND-OR plane and shapes it into the signal on a device pin. Two configuration bits decide the shaping. The first picks true or inverted polarity of the sum term. The second picks between the resulting combinational value and a copy of it held in an edge-triggered flip-flop.

The selected value reaches a bidirectional pad through a three-state driver. When the driver is off, the pad floats, so an outside source can drive it. In that state the cell acts purely as an input. Two feedback outputs return values to the array. One carries the resolved pad level and the other carries the flip-flop state, whatever the mode or enable.

The configuration is static. It is copied into internal holding registers on every clock edge while reset is high. After reset is released, changes on the configuration inputs have no effect until the next reset. The flip-flop shares the same synchronous reset.

Top module: `cpld_macrocell`

## Requirements
- R1: On a rising clock edge with `rst` high, the flip-flop clears, so `reg_fb` reads 0 after that edge.
- R2: `cfg_invert` and `cfg_comb` are captured only on edges where `rst` is high. Changes to them while `rst` is low have no effect on `pad`, `pin_fb` or `reg_fb`.
- R3: The internal value G equals `sum_in` when the captured invert bit is 0, and equals `~sum_in` when it is 1.
- R4: When the captured combinational bit is 1, the cell output follows G in the same cycle, with no clock edge in between.
- R5: When the captured combinational bit is 0, the cell output equals the value of G sampled at the most recent rising edge with `rst` low.
- R6: When `oe` is 1, the cell drives `pad` with its output, and `pin_fb` shows that value.
- R7: When `oe` is 0, the cell does not drive `pad`. `pin_fb` then shows the level an external source puts on `pad`.
- R8: `reg_fb` always shows the flip-flop state. It tracks G sampled at each edge regardless of `oe` and of the combinational bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also loads configuration |
| sum_in | input | 1 | Sum term from the OR plane |
| cfg_invert | input | 1 | 1 selects the complemented sum term |
| cfg_comb | input | 1 | 1 selects the combinational path, 0 the registered path |
| oe | input | 1 | Output enable of the pad driver |
| pad | inout | 1 | Bidirectional device pin |
| pin_fb | output | 1 | Resolved pad level fed back to the array |
| reg_fb | output | 1 | Flip-flop state fed back to the array |

## Verification
The main function is tried with all eight combinations of polarity, path and enable. Each combination is checked just before the first clock edge after reset and again just after it. That pair separates the combinational path, which shows G immediately, from the registered path, which still shows 0. An alternating sum-term sequence on the inverted registered path shows the one-cycle lag and the inversion together. Toggling configuration inputs after reset shows they are ignored. Driving the pad from outside with the enable low shows that the feedback follows the external level while the flip-flop keeps tracking G.

// File: rtl/cpld_macrocell.sv
module cpld_macrocell (
  input  logic clk,
  input  logic rst,
  input  logic sum_in,
  input  logic cfg_invert,
  input  logic cfg_comb,
  input  logic oe,
  inout  wire  pad,
  output logic pin_fb,
  output logic reg_fb
);

  logic inv_q;
  logic comb_q;
  logic q;
  logic g;
  logic mc_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q  <= cfg_invert;
      comb_q <= cfg_comb;
    end
  end

  assign g = inv_q ? ~sum_in : sum_in;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= g;
  end

  assign mc_out = comb_q ? g : q;
  assign pad    = oe ? mc_out : 1'bz;
  assign pin_fb = pad;
  assign reg_fb = q;

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !reg_fb);

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(inv_q) && $stable(comb_q)));

  p_comb_path_r4: assert property (@(posedge clk) disable iff (rst)
    (oe && comb_q) |-> (pin_fb == (sum_in ^ inv_q)));

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (reg_fb == ($past(sum_in) ^ $past(inv_q))));

  p_drive_r6: assert property (@(posedge clk) disable iff (rst)
    oe |-> (pin_fb == mc_out));

endmodule

// File: tb/cpld_macrocell_test.sv
`timescale 1ns/1ps
module cpld_macrocell_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sum_in = 1'b0;
  logic cfg_invert = 1'b0;
  logic cfg_comb = 1'b0;
  logic oe = 1'b0;
  logic ext_en = 1'b0;
  logic ext_val = 1'b0;
  wire  pad;
  logic pin_fb;
  logic reg_fb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign pad = ext_en ? ext_val : 1'bz;

  always #10 clk = ~clk;

  cpld_macrocell uut (
    .clk(clk), .rst(rst), .sum_in(sum_in), .cfg_invert(cfg_invert),
    .cfg_comb(cfg_comb), .oe(oe), .pad(pad), .pin_fb(pin_fb), .reg_fb(reg_fb)
  );

  // fields: {invert, comb, oe, sum, external level}
  localparam logic [4:0] VEC [8] = '{
    5'b00_1_1_0, 5'b10_1_1_0, 5'b01_1_1_0, 5'b11_1_0_0,
    5'b00_0_1_0, 5'b10_0_0_1, 5'b01_0_0_1, 5'b11_0_1_1
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic inv, input logic comb);
    rst = 1'b1; cfg_invert = inv; cfg_comb = comb; oe = 1'b0; ext_en = 1'b0;
    step();
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      logic inv, comb, en, f, ext, g;
      {inv, comb, en, f, ext} = VEC[i];
      g = f ^ inv;
      load_cfg(inv, comb);
      sum_in = f; oe = en; ext_en = !en; ext_val = ext;
      #2;
      check("R1 reg cleared", reg_fb, 1'b0);
      check(en ? (comb ? "R4 comb path" : "R5 reg lag") : "R7 external in",
            pin_fb, en ? (comb ? g : 1'b0) : ext);
      step();
      check("R3/R8 polarity into reg", reg_fb, g);
      check(en ? "R6 drive after edge" : "R7 external held", pin_fb, en ? g : ext);
    end

    // R2: configuration changes after reset are ignored
    load_cfg(1'b0, 1'b1);
    cfg_invert = 1'b1; cfg_comb = 1'b0;
    sum_in = 1'b1; oe = 1'b1;
    #2;
    check("R2 cfg ignored comb", pin_fb, 1'b1);
    step();
    check("R2 cfg ignored polarity", reg_fb, 1'b1);
    sum_in = 1'b0;
    #2;
    check("R2 still comb", pin_fb, 1'b0);

    // R5: inverted registered sequence
    load_cfg(1'b1, 1'b0);
    oe = 1'b1;
    begin
      logic prev;
      prev = 1'b0;
      for (int k = 0; k < 6; k++) begin
        sum_in = k[0] ^ k[1];
        #2;
        check("R5 holds previous", pin_fb, prev);
        step();
        prev = ~(k[0] ^ k[1]);
        check("R5 registered inverted", pin_fb, prev);
      end
    end

    // R7/R8: pad as input while reg keeps tracking
    oe = 1'b0; ext_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      ext_val = k[0]; sum_in = k[1];
      #2;
      check("R7 pad input", pin_fb, k[0]);
      step();
      check("R8 reg tracks with oe low", reg_fb, ~k[1]);
    end

    // R1: reset in mid run clears a set register
    ext_en = 1'b0; oe = 1'b1; sum_in = 1'b0;
    step();
    check("R1 reg set before reset", reg_fb, 1'b1);
    rst = 1'b1;
    step();
    check("R1 reset clears", reg_fb, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule